// File: doc/BRIEF.md
# Timing Register Byte Loader

This block fills a bank of 12-bit timing registers from an 8-bit parallel bus. Each bus transfer is marked by a strobe, and the block acts on the strobe's high-to-low transition. A select line sets the meaning of each transfer. It either replaces the address held in the address counter, or it carries a data byte for the register that the counter points at.

A register value takes two data transfers. The first carries bits 7:0. The second carries bits 11:8 in its lower four bus bits, and its upper four bus bits are ignored. Only the second transfer produces a write. The decoder turns the current address into a one-hot write enable, which is presented for one cycle together with the assembled 12-bit word. An address above the last register enables nothing. When the step input is high at a completing transfer, the counter moves on by one so that a bank can be loaded in sequence. A synchronous clear returns the counter to address 0 and the byte phase to the low byte.

Top module: `tmg_reg_loader`

## Requirements
- R1: After reset `reg_we` is all zero, the address is 0 and the byte phase is low, so the first two data transfers write register 0.
- R2: A transfer with `sel_addr`=1 loads the address counter from `bus_din`, returns the byte phase to low (discarding a pending low byte) and produces no write.
- R3: A data transfer in the low phase stores bits 7:0 and produces no write. The next data transfer produces `reg_wdata` = {`bus_din`[3:0], stored byte}, and `bus_din`[7:4] of that transfer is ignored.
- R4: If `ld_strobe` is sampled high at one rising clock edge and low at the next, that second edge performs the transfer. `reg_we` and `reg_wdata` are valid in the cycle after it, and `reg_we` is high for exactly one cycle.
- R5: Only a high-to-low transition of `ld_strobe` performs a transfer. Holding the strobe high or low for many cycles, or raising it, has no effect, and a long high strobe still counts as one transfer.
- R6: A completed write to address a < 12 drives `reg_we` with only bit a set; at no time is more than one bit set.
- R7: A completed write to an address of 12 or above drives no enable bit. Byte phase and auto-step still behave as for a mapped address.
- R8: If `auto_step` is 1 at a completing data transfer, the address advances by one and wraps from 255 to 0. If `auto_step` is 0, the address is kept.
- R9: `clr` high at a rising edge sets the address to 0 and the byte phase to low, and it cancels any transfer at that edge. `reg_we` is zero in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of address and byte phase |
| ld_strobe | input | 1 | Transfer strobe, acted on at its falling transition |
| sel_addr | input | 1 | 1: transfer loads address, 0: transfer carries data byte |
| auto_step | input | 1 | Advance address after each completed data write |
| bus_din | input | 8 | Byte bus |
| reg_we | output | 12 | One-hot write enable per timing register |
| reg_wdata | output | 12 | Assembled register value |

## Verification
A write appears in the cycle after the rising edge that first samples the strobe low, which is one cycle after the driver drops the strobe. The driver therefore stamps each expected write with the current cycle count plus one when it lowers the strobe. The monitor pops the item when `reg_we` goes high and compares the cycle, the enable vector and the data. The monitor treats any enable seen with an empty queue as a failure, which catches extra pulses, writes to unmapped addresses, writes cancelled by clear and writes from address transfers. After each stimulus that must have no effect, the bench checks that the queue has drained.

// File: rtl/tmg_reg_loader_pkg.sv
// Package: shared types for the timing register byte loader.
// Assumes nothing beyond IEEE 1800-2017.
package tmg_reg_loader_pkg;
    // Which half of a 12-bit register the next data transfer carries.
    typedef enum logic {
        PH_LO = 1'b0,
        PH_HI = 1'b1
    } byte_phase_e;
endpackage

// File: rtl/tmg_strobe_edge.sv
// Module: tmg_strobe_edge
// Detects the high-to-low transition of the transfer strobe.
// Assumes the strobe is synchronous to clk. The pulse is combinational and
// is high in the cycle where the strobe is first sampled low.
module tmg_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic fall
);
    logic strobe_q;

    // Remember the previous strobe level.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe;
    end

    // Falling transition: high last cycle, low now.
    always_comb fall = strobe_q & ~strobe;
endmodule

// File: rtl/tmg_byte_asm.sv
// Module: tmg_byte_asm
// Tracks the byte phase and builds a register word from two data transfers.
// Assumes DIN_W < REG_W <= 2*DIN_W. commit and addr_ld are combinational
// qualifiers of the current falling edge, and clear overrides both.
module tmg_byte_asm
    import tmg_reg_loader_pkg::*;
#(
    parameter int DIN_W = 8,
    parameter int REG_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             fall,
    input  logic             sel_addr,
    input  logic [DIN_W-1:0] din,
    output logic             addr_ld,
    output logic             commit,
    output logic [REG_W-1:0] word
);
    localparam int HI_W = REG_W - DIN_W;

    byte_phase_e      phase_q;
    logic [DIN_W-1:0] low_q;
    logic             data_xfer;

    // Classify the current transfer.
    always_comb begin
        addr_ld   = fall & ~clear & sel_addr;
        data_xfer = fall & ~clear & ~sel_addr;
        commit    = data_xfer & (phase_q == PH_HI);
        word      = {din[HI_W-1:0], low_q};
    end

    // Advance the byte phase; an address load or clear resets it.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)  phase_q <= PH_LO;
        else if (addr_ld)     phase_q <= PH_LO;
        else if (data_xfer)   phase_q <= (phase_q == PH_LO) ? PH_HI : PH_LO;
    end

    // Hold the low byte until the upper part arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  low_q <= '0;
        else if (data_xfer && (phase_q == PH_LO))    low_q <= din;
    end
endmodule

// File: rtl/tmg_addr_ctr.sv
// Module: tmg_addr_ctr
// Address register with load and increment. It wraps naturally at 2**ADDR_W.
// Assumes load and step are never high together (they come from distinct
// transfer types). Clear takes priority.
module tmg_addr_ctr #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);
    // Load, step or clear the address.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) addr <= '0;
        else if (load)       addr <= load_val;
        else if (step)       addr <= addr + ADDR_W'(1);
    end
endmodule

// File: rtl/tmg_addr_dec.sv
// Module: tmg_addr_dec
// Decodes the current address into one enable per register, gated by commit.
// Assumes NUM_REGS <= 2**ADDR_W. Addresses at or above NUM_REGS enable nothing.
module tmg_addr_dec #(
    parameter int ADDR_W   = 8,
    parameter int NUM_REGS = 12
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                commit,
    output logic [NUM_REGS-1:0] en
);
    // One comparator per register.
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
        always_comb en[i] = commit & (addr == ADDR_W'(i));
    end
endmodule

// File: rtl/tmg_reg_loader.sv
// Module: tmg_reg_loader (top)
// Loads REG_W-bit timing registers from a DIN_W-bit bus on the falling edge
// of the transfer strobe. Enables and data are registered and last one cycle.
// Assumes all inputs are synchronous to clk.
module tmg_reg_loader #(
    parameter int DIN_W    = 8,
    parameter int REG_W    = 12,
    parameter int NUM_REGS = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                ld_strobe,
    input  logic                sel_addr,
    input  logic                auto_step,
    input  logic [DIN_W-1:0]    bus_din,
    output logic [NUM_REGS-1:0] reg_we,
    output logic [REG_W-1:0]    reg_wdata
);
    localparam int ADDR_W = DIN_W;

    logic              fall;
    logic              addr_ld;
    logic              commit;
    logic [REG_W-1:0]  word;
    logic [ADDR_W-1:0] addr;
    logic [NUM_REGS-1:0] en;

    tmg_strobe_edge edge_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (ld_strobe),
        .fall   (fall)
    );

    tmg_byte_asm #(.DIN_W(DIN_W), .REG_W(REG_W)) asm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clr),
        .fall     (fall),
        .sel_addr (sel_addr),
        .din      (bus_din),
        .addr_ld  (addr_ld),
        .commit   (commit),
        .word     (word)
    );

    tmg_addr_ctr #(.ADDR_W(ADDR_W)) ctr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clr),
        .load     (addr_ld),
        .load_val (bus_din),
        .step     (commit & auto_step),
        .addr     (addr)
    );

    tmg_addr_dec #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) dec_i (
        .addr   (addr),
        .commit (commit),
        .en     (en)
    );

    // Register the enables so that each write lasts exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) reg_we <= '0;
        else        reg_we <= en;
    end

    // Capture the assembled word on each completed data write.
    always_ff @(posedge clk) begin
        if (!rst_n)      reg_wdata <= '0;
        else if (commit) reg_wdata <= word;
    end
endmodule

// File: rtl/tmg_reg_loader_chk.sv
// Module: tmg_reg_loader_chk
// Assertion checker bound to tmg_reg_loader. It observes ports only.
module tmg_reg_loader_chk #(
    parameter int HI_W     = 4,
    parameter int NUM_REGS = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                clr,
    input logic                ld_strobe,
    input logic                sel_addr,
    input logic [HI_W-1:0]     din_hi,
    input logic [NUM_REGS-1:0] reg_we,
    input logic [HI_W-1:0]     wdata_hi
);
    AST_ENABLE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reg_we)); // R6
    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|reg_we) |=> !(|reg_we)); // R4
    AST_WRITE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (|reg_we) |-> ($past(ld_strobe, 2) && !$past(ld_strobe))); // R5
    AST_NO_WRITE_ON_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (|reg_we) |-> !$past(sel_addr)); // R2
    AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !(|reg_we)); // R9
    AST_UPPER_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (|reg_we) |-> (wdata_hi == $past(din_hi))); // R3
endmodule

bind tmg_reg_loader tmg_reg_loader_chk #(
    .HI_W     (REG_W - DIN_W),
    .NUM_REGS (NUM_REGS)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .ld_strobe (ld_strobe),
    .sel_addr  (sel_addr),
    .din_hi    (bus_din[REG_W-DIN_W-1:0]),
    .reg_we    (reg_we),
    .wdata_hi  (reg_wdata[REG_W-1:DIN_W])
);

// File: tb/tmg_reg_loader_tb_top.sv
`timescale 1ns/1ps
module tmg_reg_loader_tb_top;
    localparam int NREG = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            clr = 1'b0;
    logic            ld_strobe = 1'b0;
    logic            sel_addr = 1'b0;
    logic            auto_step = 1'b0;
    logic [7:0]      bus_din = 8'h00;
    logic [NREG-1:0] reg_we;
    logic [11:0]     reg_wdata;

    int unsigned cyc = 0;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [NREG-1:0] q_en[$];
    logic [11:0]     q_data[$];
    int unsigned     q_cyc[$];
    string           q_tag[$];

    tmg_reg_loader dut_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .ld_strobe(ld_strobe),
        .sel_addr(sel_addr), .auto_step(auto_step), .bus_din(bus_din),
        .reg_we(reg_we), .reg_wdata(reg_wdata)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pop an expected write whenever an enable appears.
    always @(negedge clk) begin
        if (rst_n && (|reg_we)) begin
            total++;
            if (q_en.size() == 0) begin
                bad++;
                $display("FAIL unexpected write (R7/R2/R5/R9): we=%h data=%h expected no write", reg_we, reg_wdata);
            end else begin
                logic [NREG-1:0] e_en;
                logic [11:0] e_d;
                int unsigned e_c;
                string t;
                e_en = q_en.pop_front(); e_d = q_data.pop_front();
                e_c = q_cyc.pop_front(); t = q_tag.pop_front();
                if (reg_we !== e_en || reg_wdata !== e_d || cyc != e_c) begin
                    bad++;
                    $display("FAIL %s: we=%h data=%h cyc=%0d expected we=%h data=%h cyc=%0d",
                             t, reg_we, reg_wdata, cyc, e_en, e_d, e_c);
                end
            end
        end
    end

    // One transfer; optionally push the write it completes.
    task automatic xfer(input bit sel, input logic [7:0] d, input bit push,
                        input int a, input logic [11:0] v, input string tag);
        @(negedge clk);
        sel_addr = sel; bus_din = d; ld_strobe = 1'b1;
        @(negedge clk);
        ld_strobe = 1'b0;
        if (push) begin
            q_en.push_back(NREG'(1) << a); q_data.push_back(v);
            q_cyc.push_back(cyc + 1); q_tag.push_back(tag);
        end
        @(negedge clk);
    endtask

    // Two data transfers; upper bus nibble carries junk that must be ignored.
    task automatic wr_word(input logic [11:0] v, input int a, input string tag);
        xfer(1'b0, v[7:0], 1'b0, 0, 12'h0, tag);
        xfer(1'b0, {4'hD, v[11:8]}, (a < NREG), a, v, tag);
    endtask

    task automatic set_addr(input logic [7:0] a);
        xfer(1'b1, a, 1'b0, 0, 12'h0, "R2");
    endtask

    // Check that every expected write has been seen.
    task automatic drained(input string tag);
        repeat (3) @(negedge clk);
        total++;
        if (q_en.size() != 0) begin
            bad++;
            $display("FAIL %s: %0d writes missing, expected 0", tag, q_en.size());
            q_en.delete(); q_data.delete(); q_cyc.delete(); q_tag.delete();
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        total++;
        if (reg_we !== '0) begin
            bad++; $display("FAIL R1: we=%h expected 000", reg_we);
        end
        wr_word(12'h123, 0, "R1 first write to reg 0");
        drained("R1");
        set_addr(8'd5);
        wr_word(12'hABC, 5, "R3 two-byte assembly");
        drained("R2");
        // Address load mid-pair discards the pending low byte.
        xfer(1'b0, 8'h77, 1'b0, 0, 12'h0, "R2");
        set_addr(8'd3);
        wr_word(12'h456, 3, "R2 phase reset by address load");
        drained("R2");
        // Auto-step across the last register into unmapped space.
        auto_step = 1'b1;
        set_addr(8'd10);
        wr_word(12'h010, 10, "R8 step write a");
        wr_word(12'h011, 11, "R6 last register");
        wr_word(12'hFFF, 12, "R7");
        wr_word(12'hEEE, 13, "R7");
        drained("R7 unmapped ignored");
        wr_word(12'h00E, 14, "R7");
        set_addr(8'd255);
        wr_word(12'h0FF, 255, "R8");
        wr_word(12'h321, 0, "R8 wrap to 0");
        drained("R8");
        auto_step = 1'b0;
        wr_word(12'h654, 1, "R8 step then hold");
        wr_word(12'h987, 1, "R8 no step");
        drained("R8");
        // Long high strobe, then levels held: one transfer only.
        xfer(1'b0, 8'h5A, 1'b0, 0, 12'h0, "R5");
        @(negedge clk); sel_addr = 1'b0; bus_din = 8'h0C; ld_strobe = 1'b1;
        repeat (6) @(negedge clk);
        ld_strobe = 1'b0;
        q_en.push_back(NREG'(1) << 1); q_data.push_back(12'hC5A);
        q_cyc.push_back(cyc + 1); q_tag.push_back("R5 long strobe");
        repeat (6) @(negedge clk);
        drained("R5 levels held");
        // Clear coinciding with a falling edge cancels it.
        xfer(1'b0, 8'h11, 1'b0, 0, 12'h0, "R9");
        @(negedge clk); sel_addr = 1'b0; bus_din = 8'h02; ld_strobe = 1'b1;
        @(negedge clk); ld_strobe = 1'b0; clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        drained("R9 cancelled write");
        wr_word(12'h789, 0, "R9 clear to address 0");
        drained("R9");
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule